// File: doc/BRIEF.md
# Arithmetic Unit With Status Flags

This block is a 16-bit integer arithmetic unit. It computes its results without a clock and keeps its status flags in a register. One opcode chooses the operation: copy, swap, add, subtract, step up, step down or two's-complement negate. The results appear on the outputs in the same cycle as the operands. The five status bits are carry, parity, zero, sign and signed overflow. They are written only on a cycle where the execute strobe is high.

Each class of operation writes its own set of status bits. Full arithmetic operations (add, subtract, negate) write all five. Step operations write every bit except carry. Copy, swap and the reserved opcode write none. The surrounding datapath uses the two result outputs as the new values of its destination and source operands. It reads the flag outputs for condition tests on later cycles.

Top module: `arith_flag_unit`

## Requirements
- R1: `result` depends on `op_sel` as follows: 0 copy gives B, 2 add gives A+B, 3 subtract gives A-B, 4 step up gives A+1, 5 step down gives A-1, 6 negate gives 0-A, and the reserved code 7 gives A. All results are taken modulo 2^16 and appear in the same cycle as the inputs.
- R2: `result_alt` equals A for code 1 (swap), where `result` equals B. For every other code `result_alt` equals B.
- R3: After a strobed add, carry is 1 exactly when the unsigned sum exceeds FFFFh. After a strobed subtract, carry is 1 exactly when A < B as unsigned values.
- R4: After a strobed add, subtract, step or negate, overflow is 1 exactly when the true signed result lies outside -32768..32767.
- R5: After a strobed add, subtract, step or negate, parity is 1 when `result` holds an even number of one bits and 0 when the count is odd.
- R6: After a strobed add, subtract, step or negate, zero is 1 exactly when `result` is 0000h, and sign equals bit 15 of `result`.
- R7: A strobed copy, swap or reserved code leaves all five flags unchanged.
- R8: A strobed step up or step down updates parity, zero, sign and overflow but keeps carry at its previous value.
- R9: After a strobed negate, carry is 1 unless the result is 0000h.
- R10: On a clock edge where `exec_en` is low, all flags keep their values.
- R11: A clock edge with `rst` high clears all five flags to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset of the flag register, active high |
| exec_en | input | 1 | Execute strobe; flags load on an edge where it is high |
| op_sel | input | 3 | Operation code |
| opnd_a | input | 16 | Operand A (destination value) |
| opnd_b | input | 16 | Operand B (source value) |
| result | output | 16 | Primary result |
| result_alt | output | 16 | Second result, used by swap |
| flag_carry | output | 1 | Carry / borrow flag |
| flag_parity | output | 1 | Even-parity flag |
| flag_zero | output | 1 | Zero-result flag |
| flag_sign | output | 1 | Sign flag |
| flag_ovf | output | 1 | Signed overflow flag |

## Verification
The temporal checks assume that `op_sel`, `opnd_a` and `opnd_b` stay constant from the point where the strobe is sampled until the clock edge that loads the flags. They also assume `rst` is high at the first edge, so the flag register starts from a known value. The stimulus applies every operand change at the falling edge and holds it through the next rising edge. It starts with reset asserted for several cycles. Operands cover a grid of sign-boundary, all-ones and alternating patterns for every opcode, followed by a long pseudo-random run. The strobe is withheld on a regular fraction of cycles.

// File: rtl/afu_pkg.sv
package afu_pkg;

   typedef enum logic [2:0] {
      OP_COPY = 3'd0,
      OP_SWAP = 3'd1,
      OP_ADD  = 3'd2,
      OP_SUB  = 3'd3,
      OP_INC  = 3'd4,
      OP_DEC  = 3'd5,
      OP_NEG  = 3'd6,
      OP_RSV  = 3'd7
   } afu_op_e;

   typedef struct packed {
      logic cf;
      logic pf;
      logic zf;
      logic sf;
      logic vf;
   } afu_flags_t;

   // which flag groups a given opcode is allowed to write
   function automatic logic writes_all(afu_op_e op);
      return (op == OP_ADD) || (op == OP_SUB) || (op == OP_NEG);
   endfunction

   function automatic logic writes_no_carry(afu_op_e op);
      return (op == OP_INC) || (op == OP_DEC);
   endfunction

endpackage

// File: rtl/afu_datapath.sv
module afu_datapath
   import afu_pkg::*;
#(
   parameter int WIDTH = 16
) (
   input  afu_op_e          op,
   input  logic [WIDTH-1:0] opa,
   input  logic [WIDTH-1:0] opb,
   output logic [WIDTH-1:0] res,
   output logic [WIDTH-1:0] res_alt,
   output logic             carry_raw,
   output logic             ovf_raw
);
   localparam int MSB = WIDTH - 1;

   generate
      if (WIDTH < 2) begin : g_bad_width
         $error("afu_datapath: WIDTH must be at least 2");
      end
   endgenerate

   logic [WIDTH-1:0] add_x;
   logic [WIDTH-1:0] add_y;
   logic             add_cin;
   logic [WIDTH:0]   add_sum;
   logic             is_borrow_op;

   // one shared adder; each arithmetic opcode maps onto x + y + cin
   always_comb begin
      add_x        = opa;
      add_y        = opb;
      add_cin      = 1'b0;
      is_borrow_op = 1'b0;
      unique case (op)
         OP_ADD: begin
            add_y = opb;
         end
         OP_SUB: begin
            add_y        = ~opb;
            add_cin      = 1'b1;
            is_borrow_op = 1'b1;
         end
         OP_INC: begin
            add_y   = '0;
            add_cin = 1'b1;
         end
         OP_DEC: begin
            add_y        = '1;
            is_borrow_op = 1'b1;
         end
         OP_NEG: begin
            add_x        = '0;
            add_y        = ~opa;
            add_cin      = 1'b1;
            is_borrow_op = 1'b1;
         end
         default: begin
            add_y = opb;
         end
      endcase
   end

   assign add_sum = {1'b0, add_x} + {1'b0, add_y} + {{WIDTH{1'b0}}, add_cin};

   always_comb begin
      res_alt = opb;
      unique case (op)
         OP_COPY: res = opb;
         OP_SWAP: begin
            res     = opb;
            res_alt = opa;
         end
         OP_RSV:  res = opa;
         default: res = add_sum[MSB:0];
      endcase
   end

   // a borrow is the inverse of the adder carry for the subtract forms
   assign carry_raw = is_borrow_op ? ~add_sum[WIDTH] : add_sum[WIDTH];
   assign ovf_raw   = (add_x[MSB] == add_y[MSB]) && (add_sum[MSB] != add_x[MSB]);

endmodule

// File: rtl/afu_status_eval.sv
module afu_status_eval #(
   parameter int WIDTH    = 16,
   parameter bit PAR_TREE = 1'b1
) (
   input  logic [WIDTH-1:0] res,
   output logic             par_even,
   output logic             is_zero,
   output logic             is_neg
);
   generate
      if (WIDTH < 2) begin : g_bad_width
         $error("afu_status_eval: WIDTH must be at least 2");
      end

      if (PAR_TREE) begin : g_par_chain
         logic [WIDTH-1:0] xacc;
         assign xacc[0] = res[0];
         for (genvar i = 1; i < WIDTH; i++) begin : g_stage
            assign xacc[i] = xacc[i-1] ^ res[i];
         end
         assign par_even = ~xacc[WIDTH-1];
      end else begin : g_par_reduce
         assign par_even = ~(^res);
      end
   endgenerate

   assign is_zero = (res == '0);
   assign is_neg  = res[WIDTH-1];

endmodule

// File: rtl/afu_flag_reg.sv
module afu_flag_reg
   import afu_pkg::*;
(
   input  logic       clk,
   input  logic       rst,
   input  logic       strobe,
   input  afu_op_e    op,
   input  afu_flags_t nxt,
   output afu_flags_t cur
);
   logic wr_all;
   logic wr_rest;

   assign wr_all  = strobe && writes_all(op);
   assign wr_rest = strobe && (writes_all(op) || writes_no_carry(op));

   always_ff @(posedge clk) begin
      if (rst) begin
         cur <= '0;
      end else begin
         if (wr_all) begin
            cur.cf <= nxt.cf;
         end
         if (wr_rest) begin
            cur.pf <= nxt.pf;
            cur.zf <= nxt.zf;
            cur.sf <= nxt.sf;
            cur.vf <= nxt.vf;
         end
      end
   end

   p_reset_clear_r11: assert property (@(posedge clk) rst |=> (cur == '0))
      else $error("flags not cleared by reset");

   p_idle_hold_r10: assert property (@(posedge clk) disable iff (rst)
      !strobe |=> $stable(cur))
      else $error("flags changed without strobe");

   p_move_keep_r7: assert property (@(posedge clk) disable iff (rst)
      (strobe && (op == OP_COPY || op == OP_SWAP || op == OP_RSV)) |=> $stable(cur))
      else $error("copy/swap/reserved altered flags");

   p_step_carry_r8: assert property (@(posedge clk) disable iff (rst)
      (strobe && (op == OP_INC || op == OP_DEC)) |=> $stable(cur.cf))
      else $error("step operation altered carry");

endmodule

// File: rtl/arith_flag_unit.sv
module arith_flag_unit
   import afu_pkg::*;
#(
   parameter int WIDTH    = 16,
   parameter bit PAR_TREE = 1'b1
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             exec_en,
   input  logic [2:0]       op_sel,
   input  logic [WIDTH-1:0] opnd_a,
   input  logic [WIDTH-1:0] opnd_b,
   output logic [WIDTH-1:0] result,
   output logic [WIDTH-1:0] result_alt,
   output logic             flag_carry,
   output logic             flag_parity,
   output logic             flag_zero,
   output logic             flag_sign,
   output logic             flag_ovf
);
   localparam int MSB = WIDTH - 1;

   generate
      if (WIDTH < 2) begin : g_bad_width
         $error("arith_flag_unit: WIDTH must be at least 2");
      end
   endgenerate

   afu_op_e    op;
   logic       c_raw;
   logic       v_raw;
   logic       p_eval;
   logic       z_eval;
   logic       s_eval;
   afu_flags_t f_next;
   afu_flags_t f_cur;

   assign op = afu_op_e'(op_sel);

   afu_datapath #(.WIDTH(WIDTH)) u_dp (
      .op        (op),
      .opa       (opnd_a),
      .opb       (opnd_b),
      .res       (result),
      .res_alt   (result_alt),
      .carry_raw (c_raw),
      .ovf_raw   (v_raw)
   );

   afu_status_eval #(.WIDTH(WIDTH), .PAR_TREE(PAR_TREE)) u_eval (
      .res      (result),
      .par_even (p_eval),
      .is_zero  (z_eval),
      .is_neg   (s_eval)
   );

   assign f_next = '{cf: c_raw, pf: p_eval, zf: z_eval, sf: s_eval, vf: v_raw};

   afu_flag_reg u_flags (
      .clk    (clk),
      .rst    (rst),
      .strobe (exec_en),
      .op     (op),
      .nxt    (f_next),
      .cur    (f_cur)
   );

   assign flag_carry  = f_cur.cf;
   assign flag_parity = f_cur.pf;
   assign flag_zero   = f_cur.zf;
   assign flag_sign   = f_cur.sf;
   assign flag_ovf    = f_cur.vf;

   p_neg_carry_r9: assert property (@(posedge clk) disable iff (rst)
      (exec_en && op == OP_NEG) |=> (flag_carry == ($past(result) != '0)))
      else $error("negate carry does not track nonzero result");

   p_zero_sign_r6: assert property (@(posedge clk) disable iff (rst)
      (exec_en && (writes_all(op) || writes_no_carry(op)))
      |=> (flag_zero == ($past(result) == '0)) && (flag_sign == $past(result[MSB])))
      else $error("zero/sign flag disagrees with result");

   p_swap_pair_r2: assert property (@(posedge clk) disable iff (rst)
      (op == OP_SWAP) |-> (result == opnd_b) && (result_alt == opnd_a))
      else $error("swap outputs wrong");

endmodule

// File: tb/arith_flag_unit_bench.sv
module arith_flag_unit_bench;
   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst;
   logic        exec_en;
   logic [2:0]  op_sel;
   logic [15:0] opnd_a;
   logic [15:0] opnd_b;
   logic [15:0] result;
   logic [15:0] result_alt;
   logic        flag_carry, flag_parity, flag_zero, flag_sign, flag_ovf;

   int n_cmp = 0;
   int n_bad = 0;
   // reference flag state {c,p,z,s,v}
   logic [4:0] mdl = 5'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   arith_flag_unit u_arith_flag_unit (
      .clk(clk), .rst(rst), .exec_en(exec_en), .op_sel(op_sel),
      .opnd_a(opnd_a), .opnd_b(opnd_b), .result(result), .result_alt(result_alt),
      .flag_carry(flag_carry), .flag_parity(flag_parity), .flag_zero(flag_zero),
      .flag_sign(flag_sign), .flag_ovf(flag_ovf)
   );

   function automatic int corner(int k);
      case (k)
         0: return 'h0000;  1: return 'h0001;  2: return 'h0002;  3: return 'h7FFF;
         4: return 'h8000;  5: return 'h8001;  6: return 'hFFFF;  7: return 'hFFFE;
         8: return 'h5555;  9: return 'hAAAA; 10: return 'h00FF; 11: return 'hFF00;
         12: return 'h1234; 13: return 'h7FFE; 14: return 'h0080; default: return 'hC000;
      endcase
   endfunction

   function automatic int sgn(int v);
      return (v >= 32768) ? v - 65536 : v;
   endfunction

   function automatic int ones(int v);
      int n = 0;
      for (int i = 0; i < 16; i++) n += (v >> i) & 1;
      return n;
   endfunction

   task automatic check(string tag, int act, int exp);
      n_cmp++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s: actual %h expected %h (op=%0d a=%h b=%h)",
                  tag, act, exp, op_sel, opnd_a, opnd_b);
      end
   endtask

   // apply at a falling edge, check results, then check flags one falling edge later
   task automatic do_op(int op, int a, int b, bit en);
      int r, r2, full, c, v;
      string ftag;
      op_sel = op[2:0]; opnd_a = a[15:0]; opnd_b = b[15:0]; exec_en = en;
      r2 = b; c = 0; v = 0;
      case (op)
         0: r = b;
         1: begin r = b; r2 = a; end
         2: begin full = a + b; r = full & 'hFFFF; c = (full > 'hFFFF);
                  full = sgn(a) + sgn(b); v = (full > 32767 || full < -32768); end
         3: begin r = (a - b) & 'hFFFF; c = (a < b);
                  full = sgn(a) - sgn(b); v = (full > 32767 || full < -32768); end
         4: begin r = (a + 1) & 'hFFFF; v = (sgn(a) + 1 > 32767); end
         5: begin r = (a - 1) & 'hFFFF; v = (sgn(a) - 1 < -32768); end
         6: begin r = (0 - a) & 'hFFFF; c = (r != 0); v = (-sgn(a) > 32767); end
         default: r = a;
      endcase
      #1;
      check("R1 result", result, r);
      check("R2 result_alt", result_alt, r2);
      if (!en)                 ftag = "R10 hold";
      else if (op == 4 || op == 5) ftag = "R8 R4 R5 R6 step";
      else if (op == 6)        ftag = "R9 R4 R5 R6 negate";
      else if (op == 2 || op == 3) ftag = "R3 R4 R5 R6 add/sub";
      else                     ftag = "R7 no-write";
      if (en && (op >= 2 && op <= 6)) begin
         if (op != 4 && op != 5) mdl[4] = c[0];
         mdl[3] = (ones(r) % 2 == 0);
         mdl[2] = (r == 0);
         mdl[1] = r[15];
         mdl[0] = v[0];
      end
      @(negedge clk);
      check(ftag, {flag_carry, flag_parity, flag_zero, flag_sign, flag_ovf}, mdl);
   endtask

   initial begin
      #(CLK_PERIOD * 200000);
      n_bad++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      int seed;
      rst = 1'b1; exec_en = 1'b0; op_sel = 3'd0; opnd_a = '0; opnd_b = '0;
      repeat (3) @(negedge clk);
      check("R11 reset", {flag_carry, flag_parity, flag_zero, flag_sign, flag_ovf}, 0);
      rst = 1'b0;
      mdl = 5'b0;

      for (int op = 0; op < 8; op++)
         for (int i = 0; i < 16; i++)
            for (int j = 0; j < 16; j++)
               do_op(op, corner(i), corner(j), ((i + j) % 5) != 4);

      // known worked cases
      do_op(2, 'hFFFF, 'hFFFF, 1'b1);  // FFFE: C1 P0 Z0 S1 V0 (R3)
      check("R3 add FFFF+FFFF flags", {flag_carry, flag_parity, flag_zero, flag_sign, flag_ovf}, 5'b10010);
      do_op(3, 'h8000, 'h0001, 1'b1);  // 7FFF: C0 P0 Z0 S0 V1 (R4)
      check("R4 sub 8000-0001 flags", {flag_carry, flag_parity, flag_zero, flag_sign, flag_ovf}, 5'b00001);
      do_op(2, 'hFFFF, 'h0001, 1'b1);  // 0000: C1 P1 Z1 S0 V0
      check("R6 add FFFF+0001 flags", {flag_carry, flag_parity, flag_zero, flag_sign, flag_ovf}, 5'b11100);

      seed = 32'h1ACE5EED;
      for (int k = 0; k < 4000; k++) begin
         seed ^= seed << 13; seed ^= seed >>> 17; seed ^= seed << 5;
         do_op((seed >> 3) & 7, (seed >> 8) & 'hFFFF, seed & 'hFFFF, ((seed >> 29) & 3) != 0);
      end

      // mid-run reset after flags were set
      do_op(2, 'hFFFF, 'hFFFF, 1'b1);
      rst = 1'b1; exec_en = 1'b1; op_sel = 3'd2;
      @(negedge clk);
      check("R11 mid-run reset", {flag_carry, flag_parity, flag_zero, flag_sign, flag_ovf}, 0);
      rst = 1'b0; mdl = 5'b0;
      do_op(6, 'h0000, 'h0000, 1'b1);  // negate zero: carry 0 (R9)
      do_op(6, 'h0001, 'h0000, 1'b1);  // negate one: carry 1 (R9)

      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

endmodule